// File: doc/BRIEF.md
# Deadman Timer with Two-Step Keyed Clear

This block is a supervisory counter that software must service on a schedule. Once it is enabled, it counts system clock cycles up to a programmed period. Software keeps it alive with a two-step handshake. The first step writes an arming key to one register. The second step writes a clearing key to another register, and that key counts only while the clear window near the end of the period is open. A successful handshake restarts the count from zero.

Any of the following trips the block: a wrong arming key, a clearing key given at the wrong time or with the wrong value, or a count that runs out. A trip raises a level event output and a one-cycle reset-request pulse, and it latches a sticky reset-cause bit. The block stays tripped until software clears the enable bit. The system reset controller that acts on the request lies outside this block.

The register bus is a single-cycle write and combinational read port. The address is eight bits and the data is 32 bits.

The block is built around a four-state machine:
- `S_OFF`: the block is disabled.
- `S_RUN`: the block is counting and unarmed.
- `S_PRIMED`: the block is counting and the arming key has been accepted.
- `S_TRIPPED`: an event has occurred and the counter is frozen.

Its transitions are:
- T_ENABLE: `S_OFF` to `S_RUN`.
- T_PRIME: `S_RUN` to `S_PRIMED`.
- T_CLEAR: `S_PRIMED` to `S_RUN`.
- T_BADPRE, T_BADCLR and T_EXPIRE: `S_RUN` or `S_PRIMED` to `S_TRIPPED`.
- T_DISABLE: any active state to `S_OFF`.

Top module: `deadman_timer`

## Requirements
- R1: After reset the block is in `S_OFF`. The count, status and outputs are 0, the period register reads DEF_PERIOD and the window register reads DEF_WINDOW.
- R2: Writing 1 to bit 15 at offset 0x00 enables the block and starts the count at 0, and the count then rises by one per clock. Reading offset 0x00 returns the enable in bit 15.
- R3: The period register (0x60) and the window register (0x70) accept writes only while the block is disabled. Writes while it is enabled leave them unchanged.
- R4: Status bit 0 (offset 0x30) is 1 exactly while the block is counting and the count (0x40) is at least period minus window.
- R5: A clear sequence first writes 0x40 in bits 15:8 of offset 0x10, then writes 0x08 in bits 7:0 of offset 0x20 while the window is open. This sequence resets the count to 0, closes the window and leaves status bits 7, 6 and 5 at 0.
- R6: A write to offset 0x10 whose bits 15:8 differ from 0x40 sets status bit 7 and trips the block.
- R7: Any of the following sets status bit 6 and trips the block: a write to offset 0x20 with bits 7:0 not 0x08, a write there while the window is closed, or a write there without a preceding accepted arming key.
- R8: With no clear, the block trips exactly `period` clocks after the enable write.
- R9: On a trip, status bit 5 and `dm_event_o` go high and stay high until the block is disabled. `rst_req_o` pulses for exactly one clock, and the count freezes.
- R10: `cause_o` is set on a trip and holds across disable. A write on the cause port with bit 5 set clears it, while other bits have no effect.
- R11: Writing 0 to bit 15 at offset 0x00 returns the block to `S_OFF`. This clears status bits 7, 6 and 5, the event output and the count.
- R12: In the cycle right after a disable write, every register access is ignored: writes have no effect and reads return 0.
- R13: Key writes to offsets 0x10 and 0x20 while the block is disabled have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| cause_we_i | input | 1 | Write strobe of the reset-cause clear port |
| cause_wdata_i | input | 8 | Cause clear data; bit 5 clears the cause flag |
| dm_event_o | output | 1 | Deadman event, high while tripped |
| rst_req_o | output | 1 | One-clock reset request on each trip |
| cause_o | output | 1 | Sticky reset-cause flag |

## Verification
A wrong state shows at the ports within one clock.

A machine that leaves `S_PRIMED` on the wrong key, or that misses the arming step, shows up as a trip or a missing trip right after the clearing write. The status byte reads back 0x60 or 0xA0 against an expected 0x00. A counter or window comparator that is off by one moves the window bit or the trip edge by one clock. Directed tests sample both on the exact cycle the requirements predict.

Stale flags or a stuck event after disable are visible on the first read that follows the lockout cycle.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ARM  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_KICK = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_PER  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_WIN  = 8'h70;

    localparam int EN_BIT    = 15;
    localparam int ST_WIN    = 0;
    localparam int ST_EVT    = 5;
    localparam int ST_BADKCK = 6;
    localparam int ST_BADARM = 7;
    localparam int CAUSE_BIT = 5;

    localparam logic [7:0] ARM_KEY  = 8'h40;
    localparam logic [7:0] KICK_KEY = 8'h08;

    typedef enum logic [1:0] {
        S_OFF     = 2'd0,
        S_RUN     = 2'd1,
        S_PRIMED  = 2'd2,
        S_TRIPPED = 2'd3
    } dmt_state_e;

endpackage

// File: rtl/dmt_bus_decode.sv
module dmt_bus_decode
    import dmt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              en_data_i,
    input  logic              active_i,
    output logic              ctl_wr_o,
    output logic              arm_wr_o,
    output logic              kick_wr_o,
    output logic              per_wr_o,
    output logic              win_wr_o,
    output logic              rd_ok_o,
    output logic              lock_o
);

    logic lock_q;
    logic access_ok;

    assign access_ok = !lock_q;

    // A disable write from an active state blocks the following cycle.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lock_q <= 1'b0;
        end else begin
            lock_q <= access_ok && we_i && (addr_i == OFS_CTL) && !en_data_i && active_i;
        end
    end

    always_comb begin
        ctl_wr_o  = access_ok && we_i && (addr_i == OFS_CTL);
        arm_wr_o  = access_ok && we_i && (addr_i == OFS_ARM)  && active_i;
        kick_wr_o = access_ok && we_i && (addr_i == OFS_KICK) && active_i;
        per_wr_o  = access_ok && we_i && (addr_i == OFS_PER)  && !active_i;
        win_wr_o  = access_ok && we_i && (addr_i == OFS_WIN)  && !active_i;
        rd_ok_o   = access_ok && re_i;
    end

    assign lock_o = lock_q;

endmodule

// File: rtl/dmt_counter.sv
module dmt_counter
    import dmt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int DEF_PERIOD = 1000,
    parameter int DEF_WINDOW = 250
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             zero_i,
    input  logic             per_wr_i,
    input  logic             win_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o,
    output logic [CNT_W-1:0] win_o,
    output logic             win_open_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] win_q;
    logic [CNT_W-1:0] open_at;
    logic [CNT_W:0]   cnt_next_wide;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            per_q <= CNT_W'(DEF_PERIOD);
            win_q <= CNT_W'(DEF_WINDOW);
        end else begin
            if (per_wr_i) per_q <= wdata_i;
            if (win_wr_i) win_q <= wdata_i;
        end
    end

    assign cnt_next_wide = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign expire_o      = run_i && (cnt_next_wide >= {1'b0, per_q});
    assign open_at       = (win_q >= per_q) ? '0 : (per_q - win_q);
    assign win_open_o    = run_i && (cnt_q >= open_at);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (zero_i) begin
            cnt_q <= '0;
        end else if (run_i && !expire_o) begin
            cnt_q <= cnt_next_wide[CNT_W-1:0];
        end
    end

    assign cnt_o = cnt_q;
    assign per_o = per_q;
    assign win_o = win_q;

endmodule

// File: rtl/dmt_fsm.sv
module dmt_fsm
    import dmt_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ctl_wr_i,
    input  logic       en_data_i,
    input  logic       arm_wr_i,
    input  logic       arm_ok_i,
    input  logic       kick_wr_i,
    input  logic       kick_ok_i,
    input  logic       win_open_i,
    input  logic       expire_i,
    input  logic       cause_clr_i,
    output dmt_state_e state_o,
    output logic       zero_o,
    output logic       bad_arm_o,
    output logic       bad_kick_o,
    output logic       evt_flag_o,
    output logic       rst_req_o,
    output logic       cause_o
);

    dmt_state_e state_q, state_d;
    logic trip, set_arm, set_kick, wipe;
    logic bad_arm_q, bad_kick_q, evt_q, req_q, cause_q;

    // Next state and transition strobes.
    always_comb begin
        state_d  = state_q;
        zero_o   = 1'b0;
        trip     = 1'b0;
        set_arm  = 1'b0;
        set_kick = 1'b0;
        wipe     = 1'b0;
        unique case (state_q)
            S_OFF: begin
                if (ctl_wr_i && en_data_i) begin          // T_ENABLE
                    state_d = S_RUN;
                    zero_o  = 1'b1;
                end
            end
            S_RUN, S_PRIMED: begin
                if (ctl_wr_i && !en_data_i) begin         // T_DISABLE
                    state_d = S_OFF;
                    zero_o  = 1'b1;
                    wipe    = 1'b1;
                end else if (arm_wr_i) begin
                    if (arm_ok_i) begin                   // T_PRIME
                        state_d = S_PRIMED;
                    end else begin                        // T_BADPRE
                        state_d = S_TRIPPED;
                        trip    = 1'b1;
                        set_arm = 1'b1;
                    end
                end else if (kick_wr_i) begin
                    if (state_q == S_PRIMED && kick_ok_i && win_open_i) begin
                        state_d = S_RUN;                  // T_CLEAR
                        zero_o  = 1'b1;
                    end else begin                        // T_BADCLR
                        state_d  = S_TRIPPED;
                        trip     = 1'b1;
                        set_kick = 1'b1;
                    end
                end else if (expire_i) begin              // T_EXPIRE
                    state_d = S_TRIPPED;
                    trip    = 1'b1;
                end
            end
            S_TRIPPED: begin
                if (ctl_wr_i && !en_data_i) begin         // T_DISABLE
                    state_d = S_OFF;
                    zero_o  = 1'b1;
                    wipe    = 1'b1;
                end
            end
            default: state_d = S_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= S_OFF;
        else         state_q <= state_d;
    end

    // Registered outputs and flags.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bad_arm_q  <= 1'b0;
            bad_kick_q <= 1'b0;
            evt_q      <= 1'b0;
            req_q      <= 1'b0;
            cause_q    <= 1'b0;
        end else begin
            req_q <= trip;
            if (wipe) begin
                bad_arm_q  <= 1'b0;
                bad_kick_q <= 1'b0;
                evt_q      <= 1'b0;
            end else begin
                if (set_arm)  bad_arm_q  <= 1'b1;
                if (set_kick) bad_kick_q <= 1'b1;
                if (trip)     evt_q      <= 1'b1;
            end
            if (trip)             cause_q <= 1'b1;
            else if (cause_clr_i) cause_q <= 1'b0;
        end
    end

    assign state_o    = state_q;
    assign bad_arm_o  = bad_arm_q;
    assign bad_kick_o = bad_kick_q;
    assign evt_flag_o = evt_q;
    assign rst_req_o  = req_q;
    assign cause_o    = cause_q;

endmodule

// File: rtl/deadman_timer.sv
module deadman_timer
    import dmt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int DEF_PERIOD = 1000,
    parameter int DEF_WINDOW = 250
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_we_i,
    input  logic              bus_re_i,
    input  logic [7:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic              cause_we_i,
    input  logic [7:0]        cause_wdata_i,
    output logic              dm_event_o,
    output logic              rst_req_o,
    output logic              cause_o
);

    dmt_state_e       state_q;
    logic             active, run;
    logic             ctl_wr, arm_wr, kick_wr, per_wr, win_wr, rd_ok, lock_q;
    logic             zero, win_open, expire;
    logic             bad_arm, bad_kick, evt_flag;
    logic [CNT_W-1:0] cnt_q, per_q, win_q;
    logic [DATA_W-1:0] stat_word;
    logic             unused_cause;

    assign active       = (state_q != S_OFF);
    assign run          = (state_q == S_RUN) || (state_q == S_PRIMED);
    assign unused_cause = ^{cause_wdata_i[7:6], cause_wdata_i[4:0]};

    dmt_bus_decode u_dec (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (bus_we_i),
        .re_i      (bus_re_i),
        .addr_i    (bus_addr_i),
        .en_data_i (bus_wdata_i[EN_BIT]),
        .active_i  (active),
        .ctl_wr_o  (ctl_wr),
        .arm_wr_o  (arm_wr),
        .kick_wr_o (kick_wr),
        .per_wr_o  (per_wr),
        .win_wr_o  (win_wr),
        .rd_ok_o   (rd_ok),
        .lock_o    (lock_q)
    );

    dmt_counter #(
        .CNT_W      (CNT_W),
        .DEF_PERIOD (DEF_PERIOD),
        .DEF_WINDOW (DEF_WINDOW)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run),
        .zero_i     (zero),
        .per_wr_i   (per_wr),
        .win_wr_i   (win_wr),
        .wdata_i    (bus_wdata_i[CNT_W-1:0]),
        .cnt_o      (cnt_q),
        .per_o      (per_q),
        .win_o      (win_q),
        .win_open_o (win_open),
        .expire_o   (expire)
    );

    dmt_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ctl_wr_i    (ctl_wr),
        .en_data_i   (bus_wdata_i[EN_BIT]),
        .arm_wr_i    (arm_wr),
        .arm_ok_i    (bus_wdata_i[15:8] == ARM_KEY),
        .kick_wr_i   (kick_wr),
        .kick_ok_i   (bus_wdata_i[7:0] == KICK_KEY),
        .win_open_i  (win_open),
        .expire_i    (expire),
        .cause_clr_i (cause_we_i && cause_wdata_i[CAUSE_BIT]),
        .state_o     (state_q),
        .zero_o      (zero),
        .bad_arm_o   (bad_arm),
        .bad_kick_o  (bad_kick),
        .evt_flag_o  (evt_flag),
        .rst_req_o   (rst_req_o),
        .cause_o     (cause_o)
    );

    always_comb begin
        stat_word            = '0;
        stat_word[ST_WIN]    = win_open;
        stat_word[ST_EVT]    = evt_flag;
        stat_word[ST_BADKCK] = bad_kick;
        stat_word[ST_BADARM] = bad_arm;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (rd_ok) begin
            case (bus_addr_i)
                OFS_CTL:  bus_rdata_o[EN_BIT] = active;
                OFS_STAT: bus_rdata_o = stat_word;
                OFS_CNT:  bus_rdata_o = DATA_W'(cnt_q);
                OFS_PER:  bus_rdata_o = DATA_W'(per_q);
                OFS_WIN:  bus_rdata_o = DATA_W'(win_q);
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    assign dm_event_o = (state_q == S_TRIPPED);

endmodule

// File: rtl/dmt_checker.sv
module dmt_checker
    import dmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input dmt_state_e       state_q,
    input logic             lock_q,
    input logic             win_open,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] per_q,
    input logic             dm_event_o,
    input logic             rst_req_o,
    input logic             cause_o
);

    // R9: the request lasts exactly one clock
    a_r9_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> !rst_req_o);

    // R9: a request always comes with the event level
    a_r9_req_with_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> dm_event_o);

    // R9: the count is frozen while tripped
    a_r9_cnt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dm_event_o && $past(dm_event_o)) |-> $stable(cnt_q));

    // R10: a request sets the cause flag
    a_r10_cause_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> cause_o);

    // R4: the window is closed while disabled
    a_r4_no_window_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_OFF) |-> !win_open);

    // R8: the count never passes the period
    a_r8_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == S_RUN || state_q == S_PRIMED) && per_q != '0) |-> (cnt_q < per_q));

    // R11: the disabled state has a clean count and no event
    a_r11_off_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_OFF) |-> (!dm_event_o && cnt_q == '0));

    // R12: a write during the lockout cycle cannot re-enable
    a_r12_lock_holds_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_q |=> (state_q == S_OFF));

endmodule

bind deadman_timer dmt_checker #(.CNT_W(CNT_W)) u_dmt_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_q    (state_q),
    .lock_q     (lock_q),
    .win_open   (win_open),
    .cnt_q      (cnt_q),
    .per_q      (per_q),
    .dm_event_o (dm_event_o),
    .rst_req_o  (rst_req_o),
    .cause_o    (cause_o)
);

// File: tb/tb_deadman_timer.sv
`timescale 1ns/1ps
module tb_deadman_timer;

    localparam int PER_D = 1000;
    localparam int WIN_D = 250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0, re = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        c_we = 1'b0;
    logic [7:0]  c_wdata = '0;
    logic        evt, req, cause;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    deadman_timer #(.CNT_W(32), .DEF_PERIOD(PER_D), .DEF_WINDOW(WIN_D)) dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .cause_we_i(c_we), .cause_wdata_i(c_wdata),
        .dm_event_o(evt), .rst_req_o(req), .cause_o(cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        re = 1'b1; addr = a;
        #1 d = rdata;
        re = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    // Small period so window and expiry land quickly: open from count 15.
    task automatic setup_and_enable();
        wr(8'h60, 32'd20);
        wr(8'h70, 32'd5);
        wr(8'h00, 32'h8000);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd(8'h00, v); check("R1 ctl", v, 0);
        rd(8'h30, v); check("R1 status", v, 0);
        rd(8'h40, v); check("R1 count", v, 0);
        rd(8'h60, v); check("R1 period", v, PER_D);
        rd(8'h70, v); check("R1 window", v, WIN_D);
        check("R1 outputs", {29'd0, evt, req, cause}, 0);
    endtask

    task automatic t_keys_while_off();
        logic [31:0] v;
        do_reset();
        wr(8'h10, 32'h0000_5000);
        wr(8'h20, 32'h0000_0011);
        rd(8'h30, v); check("R13 status after keys off", v, 0);
        check("R13 event", {31'd0, evt}, 0);
    endtask

    task automatic t_count_and_window();
        logic [31:0] v;
        do_reset();
        setup_and_enable();
        rd(8'h00, v); check("R2 enable readback", v, 32'h8000);
        rd(8'h40, v); check("R2 count start", v, 0);
        idle(14);
        rd(8'h40, v); check("R2 count 14", v, 14);
        rd(8'h30, v); check("R4 window shut at 14", v, 0);
        idle(1);
        rd(8'h30, v); check("R4 window open at 15", v, 1);
        wr(8'h60, 32'd99);
        rd(8'h60, v); check("R3 period locked while on", v, 20);
    endtask

    task automatic t_good_clear();
        logic [31:0] v;
        do_reset();
        setup_and_enable();
        idle(15);
        wr(8'h10, 32'h0000_4000);
        wr(8'h20, 32'h0000_0008);
        rd(8'h40, v); check("R5 count zeroed", v, 0);
        rd(8'h30, v); check("R5 status clean", v, 0);
        idle(10);
        check("R5 no event", {31'd0, evt}, 0);
    endtask

    task automatic t_expire();
        logic [31:0] v;
        do_reset();
        setup_and_enable();
        idle(19);
        check("R8 no event at 19", {31'd0, evt}, 0);
        idle(1);
        check("R8 event at period", {31'd0, evt}, 1);
        check("R9 request pulse", {31'd0, req}, 1);
        check("R10 cause set", {31'd0, cause}, 1);
        idle(1);
        check("R9 request one clock", {31'd0, req}, 0);
        check("R9 event held", {31'd0, evt}, 1);
        rd(8'h40, v); check("R9 count frozen", v, 19);
        rd(8'h30, v); check("R9 status event", v, 32'h20);
        // Disable, then exercise the lockout cycle.
        wr(8'h00, 32'h0);
        rd(8'h60, v); check("R12 read blocked", v, 0);
        wr(8'h00, 32'h8000);
        rd(8'h00, v); check("R12 write ignored", v, 0);
        rd(8'h30, v); check("R11 flags cleared", v, 0);
        rd(8'h40, v); check("R11 count cleared", v, 0);
        check("R11 event low", {31'd0, evt}, 0);
        check("R10 cause holds over disable", {31'd0, cause}, 1);
        c_we = 1'b1; c_wdata = 8'hDF; @(negedge clk); c_we = 1'b0;
        check("R10 other bits no effect", {31'd0, cause}, 1);
        c_we = 1'b1; c_wdata = 8'h20; @(negedge clk); c_we = 1'b0;
        check("R10 cause cleared", {31'd0, cause}, 0);
    endtask

    task automatic t_bad_arm();
        logic [31:0] v;
        do_reset();
        setup_and_enable();
        wr(8'h10, 32'h0000_5000);
        rd(8'h30, v); check("R6 bad arm status", v, 32'hA0);
        check("R6 event", {31'd0, evt}, 1);
    endtask

    task automatic t_bad_kick_no_arm();
        logic [31:0] v;
        do_reset();
        setup_and_enable();
        idle(16);
        wr(8'h20, 32'h0000_0008);
        rd(8'h30, v); check("R7 kick without arm", v, 32'h60);
    endtask

    task automatic t_bad_kick_early();
        logic [31:0] v;
        do_reset();
        setup_and_enable();
        wr(8'h10, 32'h0000_4000);
        wr(8'h20, 32'h0000_0008);
        rd(8'h30, v); check("R7 kick outside window", v, 32'h60);
        check("R7 event", {31'd0, evt}, 1);
    endtask

    task automatic t_bad_kick_value();
        logic [31:0] v;
        do_reset();
        setup_and_enable();
        idle(15);
        wr(8'h10, 32'h0000_4000);
        wr(8'h20, 32'h0000_0009);
        rd(8'h30, v); check("R7 wrong kick value", v, 32'h60);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_keys_while_off();
        t_count_and_window();
        t_good_clear();
        t_expire();
        t_bad_arm();
        t_bad_kick_no_arm();
        t_bad_kick_early();
        t_bad_kick_value();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule